// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of hardware semaphore flags that are shared by two processor ports, called left and right. Both ports use the same clock. Each port has a small synchronous register interface: a select, a write enable, a flag index, write data and read data. Software uses the flags to decide which side may use a shared resource at any moment, such as a region of shared memory or a peripheral.

To take a flag, a port writes a zero to it. The port then reads the same flag back: a zero means the token was granted and a one means it was denied. Because the claim is a write followed by a read, no read-modify-write cycle is needed. Each side has its own request latch for every flag. The token goes to whichever request latch shows a zero first. A request that loses stays pending. When the owner releases the flag by writing a one, the pending request takes the token in the same update. When both sides claim a free flag in the same cycle, a round-robin bit kept for each flag picks exactly one winner, and the winning side alternates from one such tie to the next.

Top module: `dual_sema_bank`

## Requirements
- R1: The bank holds NUM_SEMA (8) flags that are independent of each other. Either port selects a flag with its 3-bit index, and an operation on one flag never changes another flag.
- R2: A write happens when select=1 and write-enable=1. Write data bit 0 is stored in the writing side's request latch for the indexed flag, where 0 means request and 1 means release or cancel. Write data bits above bit 0 have no effect.
- R3: A flag that is free is taken by the first side whose latch holds a zero. Bit 0 of a read is 0 on the side that owns the flag and 1 on the other side. A free flag reads 1 on both sides. At most one side owns a flag at any time.
- R4: The owner keeps the flag until it writes a one to that flag, which releases it.
- R5: If the other side has a pending request when the owner releases, ownership passes to the other side in the same state update. The new owner then reads 0 and the old owner reads 1.
- R6: A request that fails stays pending until its own side writes a one to the same flag. A request that has been cancelled never takes ownership.
- R7: When both sides write a zero to the same free flag in the same cycle, exactly one side wins. Each flag has a round-robin bit: the left side wins the first such tie after reset, and the winner alternates on each later tie of that flag.
- R8: A read happens when select=1 and write-enable=0. Read data is registered and valid in the cycle after the strobe. Bit 0 is the port's view of the flag and all upper bits are 1. Read data holds its value when no read is made.
- R9: A synchronous active-high reset clears every request latch and frees every flag, and sets both read-data outputs to all ones. Software initialization that writes a one to every flag from both sides leaves every flag free.
- R10: A zero written by the side that already owns a flag has no effect except that the side keeps ownership. A one written by a side that neither owns the flag nor has a request pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| lCs | input | 1 | Left port select |
| lWe | input | 1 | Left write enable (0 = read) |
| lIdx | input | 3 | Left flag index |
| lWdata | input | 16 | Left write data (only bit 0 is used) |
| lRdata | output | 16 | Left registered read data |
| rCs | input | 1 | Right port select |
| rWe | input | 1 | Right write enable (0 = read) |
| rIdx | input | 3 | Right flag index |
| rWdata | input | 16 | Right write data (only bit 0 is used) |
| rRdata | output | 16 | Right registered read data |

## Verification
The bench drives the claim protocol with several different sequences, and each one separates one behaviour from the others:
- A single side claiming a flag shows a grant.
- A second side claiming a held flag shows a denial and a pending request.
- The owner releasing while a request is pending shows handover, as opposed to the flag simply becoming free.
- A request cancelled before the release shows that a withdrawn request never takes the token.

Two same-cycle ties on one flag show that the round-robin winner alternates. Holding flags on different indices at once, and writing with the upper data bits set, show that flags are independent and that only bit 0 is captured. A final pass writes ones from both sides to every flag, as software initialization would, and reads every flag back as free.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // Per-port strobes produced by the control and consumed by the datapath
  typedef struct packed {
    logic wr;     // write strobe
    logic wrVal;  // captured data bit 0
    logic rd;     // read strobe
  } portCmd_t;
endpackage

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              cs,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output portCmd_t          cmd
);
  always_comb begin
    cmd.wr    = cs & we;
    cmd.wrVal = wdata[0];
    cmd.rd    = cs & ~we;
  end
endmodule

// File: rtl/sema_datapath.sv
module sema_datapath
  import sema_pkg::*;
#(
  parameter int NUM_SEMA = 8,
  parameter int IDX_W    = $clog2(NUM_SEMA),
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  portCmd_t            lCmd,
  input  logic [IDX_W-1:0]    lIdx,
  input  portCmd_t            rCmd,
  input  logic [IDX_W-1:0]    rIdx,
  output logic [DATA_W-1:0]   lRdata,
  output logic [DATA_W-1:0]   rRdata,
  output logic [NUM_SEMA-1:0] pendL,
  output logic [NUM_SEMA-1:0] pendR,
  output logic [NUM_SEMA-1:0] ownL,
  output logic [NUM_SEMA-1:0] ownR
);
  localparam logic [DATA_W-2:0] UPPER_ONES = '1;

  logic [NUM_SEMA-1:0] rrBit;

  for (genvar i = 0; i < NUM_SEMA; i++) begin : g_flag
    logic selL, selR;
    logic pendLNext, pendRNext;
    logic keepL, keepR, tie;
    logic ownLNext, ownRNext;

    always_comb begin
      selL      = lCmd.wr && (lIdx == IDX_W'(i));
      selR      = rCmd.wr && (rIdx == IDX_W'(i));
      // pend = latch holds a zero (request active)
      pendLNext = selL ? ~lCmd.wrVal : pendL[i];
      pendRNext = selR ? ~rCmd.wrVal : pendR[i];
      keepL     = ownL[i] & pendLNext;
      keepR     = ownR[i] & pendRNext;
      tie       = pendLNext & pendRNext & ~keepL & ~keepR;
      ownLNext  = keepL | (~keepR & pendLNext & ~(tie & rrBit[i]));
      ownRNext  = keepR | (~keepL & pendRNext & ~(tie & ~rrBit[i]));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pendL[i] <= 1'b0;
        pendR[i] <= 1'b0;
        ownL[i]  <= 1'b0;
        ownR[i]  <= 1'b0;
        rrBit[i] <= 1'b0;
      end else begin
        pendL[i] <= pendLNext;
        pendR[i] <= pendRNext;
        ownL[i]  <= ownLNext;
        ownR[i]  <= ownRNext;
        if (tie) rrBit[i] <= ~rrBit[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lRdata <= '1;
      rRdata <= '1;
    end else begin
      if (lCmd.rd) lRdata <= {UPPER_ONES, ~ownL[lIdx]};
      if (rCmd.rd) rRdata <= {UPPER_ONES, ~ownR[rIdx]};
    end
  end
endmodule

// File: rtl/dual_sema_bank.sv
module dual_sema_bank
  import sema_pkg::*;
#(
  parameter int NUM_SEMA = 8,
  parameter int IDX_W    = $clog2(NUM_SEMA),
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lCs,
  input  logic              lWe,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rCs,
  input  logic              rWe,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);
  portCmd_t lCmd, rCmd;
  logic [NUM_SEMA-1:0] pendL, pendR, ownL, ownR;

  sema_ctrl #(.DATA_W(DATA_W)) u_ctrlL (
    .cs(lCs), .we(lWe), .wdata(lWdata), .cmd(lCmd)
  );
  sema_ctrl #(.DATA_W(DATA_W)) u_ctrlR (
    .cs(rCs), .we(rWe), .wdata(rWdata), .cmd(rCmd)
  );

  sema_datapath #(.NUM_SEMA(NUM_SEMA), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst),
    .lCmd(lCmd), .lIdx(lIdx), .rCmd(rCmd), .rIdx(rIdx),
    .lRdata(lRdata), .rRdata(rRdata),
    .pendL(pendL), .pendR(pendR), .ownL(ownL), .ownR(ownR)
  );
endmodule

// File: rtl/sema_checker.sv
module sema_checker #(
  parameter int NUM_SEMA = 8,
  parameter int IDX_W    = $clog2(NUM_SEMA),
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                lCs,
  input logic                lWe,
  input logic [IDX_W-1:0]    lIdx,
  input logic [DATA_W-1:0]   lWdata,
  input logic [DATA_W-1:0]   lRdata,
  input logic                rCs,
  input logic                rWe,
  input logic [IDX_W-1:0]    rIdx,
  input logic [DATA_W-1:0]   rWdata,
  input logic [DATA_W-1:0]   rRdata,
  input logic [NUM_SEMA-1:0] pendL,
  input logic [NUM_SEMA-1:0] pendR,
  input logic [NUM_SEMA-1:0] ownL,
  input logic [NUM_SEMA-1:0] ownR
);
  // R3: never two owners of one flag
  p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
    (ownL & ownR) == '0);

  // R4: an owner always has its request latch at zero
  p_owner_pending_r4: assert property (@(posedge clk) disable iff (rst)
    ((ownL & ~pendL) | (ownR & ~pendR)) == '0);

  // R5 / R6: a pending request never waits on a free flag
  p_no_idle_request_r5: assert property (@(posedge clk) disable iff (rst)
    ((pendL | pendR) & ~(ownL | ownR)) == '0);

  // R8: upper read-data bits are ones after a read
  p_upper_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (lCs && !lWe) |=> (&lRdata[DATA_W-1:1]));
  p_upper_ones_right_r8: assert property (@(posedge clk) disable iff (rst)
    (rCs && !rWe) |=> (&rRdata[DATA_W-1:1]));

  // R8: read data holds without a read strobe
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(lCs && !lWe) |=> $stable(lRdata));

  // R7: same-cycle claim of a free flag yields exactly one owner
  p_tie_one_winner_r7: assert property (@(posedge clk) disable iff (rst)
    (lCs && lWe && !lWdata[0] && rCs && rWe && !rWdata[0] && lIdx == rIdx
     && !ownL[lIdx] && !ownR[lIdx])
    |=> (ownL[$past(lIdx)] != ownR[$past(lIdx)]));
endmodule

bind dual_sema_bank sema_checker #(.NUM_SEMA(NUM_SEMA), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .lCs(lCs), .lWe(lWe), .lIdx(lIdx), .lWdata(lWdata), .lRdata(lRdata),
  .rCs(rCs), .rWe(rWe), .rIdx(rIdx), .rWdata(rWdata), .rRdata(rRdata),
  .pendL(pendL), .pendR(pendR), .ownL(ownL), .ownR(ownR)
);

// File: tb/tb_dual_sema_bank.sv
module tb_dual_sema_bank;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lCs = 0, lWe = 0, rCs = 0, rWe = 0;
  logic [2:0]    lIdx = 0, rIdx = 0;
  logic [DW-1:0] lWdata = 0, rWdata = 0;
  logic [DW-1:0] lRdata, rRdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] expLQ[$], expRQ[$];
  string         tagLQ[$], tagRQ[$];
  logic          lRdSeen = 0, rRdSeen = 0;

  always #10 clk = ~clk;

  dual_sema_bank dut (
    .clk(clk), .rst(rst),
    .lCs(lCs), .lWe(lWe), .lIdx(lIdx), .lWdata(lWdata), .lRdata(lRdata),
    .rCs(rCs), .rWe(rWe), .rIdx(rIdx), .rWdata(rWdata), .rRdata(rRdata)
  );

  // Driver: one bus cycle for both ports, inputs changed at the falling edge
  task automatic drive(input logic lc, input logic lw, input logic [2:0] li, input logic [DW-1:0] ld,
                       input logic rc, input logic rw, input logic [2:0] ri, input logic [DW-1:0] rd);
    @(negedge clk);
    lCs = lc; lWe = lw; lIdx = li; lWdata = ld;
    rCs = rc; rWe = rw; rIdx = ri; rWdata = rd;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wrL(input logic [2:0] i, input logic [DW-1:0] d);
    drive(1, 1, i, d, 0, 0, 0, 0);
  endtask

  task automatic wrR(input logic [2:0] i, input logic [DW-1:0] d);
    drive(0, 0, 0, 0, 1, 1, i, d);
  endtask

  task automatic wrBoth(input logic [2:0] i, input logic [DW-1:0] dl, input logic [DW-1:0] dr);
    drive(1, 1, i, dl, 1, 1, i, dr);
  endtask

  // Read both sides of one flag in one cycle and queue the expected views
  task automatic rdBoth(input logic [2:0] i, input logic eL, input logic eR, input string tag);
    expLQ.push_back({15'h7FFF, eL}); tagLQ.push_back(tag);
    expRQ.push_back({15'h7FFF, eR}); tagRQ.push_back(tag);
    drive(1, 0, i, 0, 1, 0, i, 0);
  endtask

  // Monitor: a read sampled at a rising edge shows at the next falling edge
  always @(posedge clk) begin
    lRdSeen <= lCs & ~lWe & ~rst;
    rRdSeen <= rCs & ~rWe & ~rst;
  end

  always @(negedge clk) begin
    if (lRdSeen) begin
      checks++;
      if (expLQ.size() == 0) begin
        errors++;
        $display("FAIL %s left: unexpected read data %h", "R8", lRdata);
      end else begin
        if (lRdata !== expLQ[0]) begin
          errors++;
          $display("FAIL %s left: got %h expected %h", tagLQ[0], lRdata, expLQ[0]);
        end
        void'(expLQ.pop_front()); void'(tagLQ.pop_front());
      end
    end
    if (rRdSeen) begin
      checks++;
      if (expRQ.size() == 0) begin
        errors++;
        $display("FAIL %s right: unexpected read data %h", "R8", rRdata);
      end else begin
        if (rRdata !== expRQ[0]) begin
          errors++;
          $display("FAIL %s right: got %h expected %h", tagRQ[0], rRdata, expRQ[0]);
        end
        void'(expRQ.pop_front()); void'(tagRQ.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R9: reset value of read data
    checks++;
    if (lRdata !== 16'hFFFF || rRdata !== 16'hFFFF) begin
      errors++;
      $display("FAIL R9 reset rdata: got %h/%h expected ffff/ffff", lRdata, rRdata);
    end
    for (int i = 0; i < 8; i++) rdBoth(3'(i), 1, 1, "R9 reset free");

    // R2/R3: left claims flag 0, with upper write bits set (R2)
    wrL(0, 16'hFFFE);
    rdBoth(0, 0, 1, "R3 grant left");
    // R1: neighbour flag untouched
    rdBoth(1, 1, 1, "R1 neighbour free");
    // R6: right request fails and stays pending
    wrR(0, 16'h0000);
    rdBoth(0, 0, 1, "R6 denied right");
    // R10: owner rewrites zero
    wrL(0, 16'h0000);
    rdBoth(0, 0, 1, "R10 owner rewrite");
    // R4/R5: release hands over to pending right
    wrL(0, 16'h0001);
    rdBoth(0, 1, 0, "R5 handover right");
    wrL(0, 16'h0000);          // left now pending
    wrR(0, 16'h0001);          // right releases
    rdBoth(0, 0, 1, "R5 handover left");
    wrL(0, 16'h0001);
    rdBoth(0, 1, 1, "R4 release free");

    // R6: cancelled request never takes the token
    wrL(3, 16'h0000);
    wrR(3, 16'h0000);
    wrR(3, 16'h0001);          // cancel
    wrL(3, 16'h0001);          // release
    rdBoth(3, 1, 1, "R6 cancel");

    // R10: idle one-write ignored, then flag still usable
    wrR(5, 16'h0001);
    rdBoth(5, 1, 1, "R10 idle release");
    wrL(5, 16'h0000);
    rdBoth(5, 0, 1, "R10 claim after idle");
    wrL(5, 16'h0001);
    // R2: upper bits do not matter on a release (bit0=1)
    wrR(5, 16'hFFFF);
    rdBoth(5, 1, 1, "R2 release data");

    // R7: ties on flag 2
    wrBoth(2, 16'h0000, 16'h0000);
    rdBoth(2, 0, 1, "R7 first tie left");
    wrL(2, 16'h0001);
    rdBoth(2, 1, 0, "R7 loser pending");
    wrR(2, 16'h0001);
    rdBoth(2, 1, 1, "R7 free");
    wrBoth(2, 16'h0000, 16'h0000);
    rdBoth(2, 1, 0, "R7 second tie right");
    wrR(2, 16'h0001);
    wrL(2, 16'h0001);

    // R1: two flags held by different sides at once
    drive(1, 1, 1, 16'h0000, 1, 1, 4, 16'h0000);
    rdBoth(1, 0, 1, "R1 flag1");
    rdBoth(4, 1, 0, "R1 flag4");

    // R9: software init writes ones from both sides
    for (int i = 0; i < 8; i++) wrBoth(3'(i), 16'h0001, 16'h0001);
    for (int i = 0; i < 8; i++) rdBoth(3'(i), 1, 1, "R9 init free");

    // R8: read data holds while idle
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (lRdata !== 16'hFFFF || rRdata !== 16'hFFFF) begin
      errors++;
      $display("FAIL R8 hold: got %h/%h expected ffff/ffff", lRdata, rRdata);
    end
    checks++;
    if (expLQ.size() != 0 || expRQ.size() != 0) begin
      errors++;
      $display("FAIL R8 pending reads: got %0d/%0d expected 0/0", expLQ.size(), expRQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule